// File: doc/BRIEF.md
# Priority interrupt acceptance unit

This block decides when a small CPU takes an interrupt. It holds the processor status word. That word has a global enable bit and a 4-bit current level in its top nibble. At each state strobe it compares the strongest pending request against a lagged copy of that word. The lagged copy is refreshed only at state strobes, so a status write from the execute stage reaches the acceptance comparator one state late. A request that arrives in that window can still be taken, even though the new word is already visible on `statusWord`.

When a request is accepted, the unit does three things in the same cycle. It presents the winner and the word being saved. It pushes that word onto an internal return stack. It replaces the live level with the winner's priority, so stronger requests remain able to interrupt the handler. A return pulse pops the stack and restores the saved word exactly, including a raised level such as 15. An atomic-sequence input holds off every acceptance while it is high.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset, `statusWord` is 0x0000, `stackOverflow` is 0 and no acceptance occurs.
- R2: With `swWrEn` high in a cycle, `statusWord` shows `swWrData` after the next clock edge.
- R3: An acceptance happens only in a cycle with `stateStrobe` high, with bit 11 (enable) set in the lagged word, and with the winning priority strictly above the lagged level (bits 15:12). A priority of 0 is never accepted.
- R4: At each strobe edge the lagged word captures the `statusWord` value held before that edge. A write therefore affects decisions only after a later strobe edge, and non-strobe cycles do not advance the lag.
- R5: Among valid requests, the highest priority wins. Equal priorities go to the lowest index. `acceptIdx` and `acceptPrio` report the winner while `acceptValid` is high.
- R6: When `acceptValid` is high, `savedWord` equals the word being pushed, which includes any same-cycle write. After the edge, bits 15:12 of `statusWord` hold the accepted priority and bits 11:0 are kept. The lagged copy takes this new word at once.
- R7: `retPulse` with a non-empty stack restores the last pushed word into both `statusWord` and the lagged copy. `retPulse` on an empty stack leaves the word unchanged. No acceptance occurs in a cycle with `retPulse` high.
- R8: While `atomicActive` is high, no request is accepted.
- R9: The stack holds 8 words. An acceptance that would push a ninth word is refused, leaves `statusWord` unchanged and sets the sticky `stackOverflow`.
- R10: With `stateStrobe` low, nothing is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stateStrobe | input | 1 | Marks a processor state boundary |
| swWrEn | input | 1 | Status word write from the execute stage |
| swWrData | input | 16 | Value to write |
| reqValid | input | 4 | Request pending, one bit per source |
| reqPrio | input | 16 | 4-bit priority per source, source i at bits 4i+3:4i |
| atomicActive | input | 1 | Atomic sequence in progress |
| retPulse | input | 1 | Return from handler |
| acceptValid | output | 1 | Request accepted this cycle (entry) |
| acceptIdx | output | 2 | Index of the winning source |
| acceptPrio | output | 4 | Priority of the winning source |
| savedWord | output | 16 | Word pushed on entry |
| statusWord | output | 16 | Live status word |
| stackOverflow | output | 1 | Sticky: an entry was refused because the stack was full |

## Verification
A lagged copy that refreshes on the wrong edge shows up at once as an acceptance outcome that is off by one state. The bench probes this with writes followed by strobe and non-strobe cycles. A wrong stack pointer or a wrong merged word shows up on `statusWord` one cycle after a return, and on `savedWord` in the entry cycle itself. Nested entries and returns compare exact word values. An arbitration or comparator fault changes `acceptValid` or `acceptIdx` in the same cycle. The full level-by-priority grid and a pseudo-random sweep over multiple requests cover these outputs.

// File: rtl/irq_accept_pkg.sv
`timescale 1ns/1ps
package irq_accept_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic doWrite;   // take the execute-stage write
    logic doShadow;  // refresh the lagged copy
    logic doPush;    // entry: save word, raise level
    logic doPop;     // return: restore saved word
    logic setOvf;    // entry refused on a full stack
  } dpCtrl_t;
endpackage

// File: rtl/irq_accept_ctrl.sv
`timescale 1ns/1ps
module irq_accept_ctrl
  import irq_accept_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int LVL_W   = 4,
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     stateStrobe,
  input  logic                     atomicActive,
  input  logic                     retPulse,
  input  logic                     swWrEn,
  input  logic [NUM_REQ-1:0]       reqValid,
  input  logic [NUM_REQ*LVL_W-1:0] reqPrio,
  input  logic                     lagEnable,
  input  logic [LVL_W-1:0]         lagLevel,
  input  logic                     stackFull,
  input  logic                     stackEmpty,
  output dpCtrl_t                  ctl,
  output logic [IDX_W-1:0]         winIdx,
  output logic [LVL_W-1:0]         winPrio,
  output logic                     acceptValid
);
  logic winVld;
  logic candidate;

  // Strict greater-than scan: highest priority wins, lowest index keeps ties,
  // and priority 0 can never win.
  always_comb begin
    winVld  = 1'b0;
    winPrio = '0;
    winIdx  = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (reqValid[i] && (reqPrio[i*LVL_W +: LVL_W] > winPrio)) begin
        winVld  = 1'b1;
        winPrio = reqPrio[i*LVL_W +: LVL_W];
        winIdx  = IDX_W'(i);
      end
    end
  end

  assign candidate = stateStrobe && !atomicActive && !retPulse &&
                     lagEnable && winVld && (winPrio > lagLevel);

  always_comb begin
    ctl.doPop    = retPulse && !stackEmpty;
    ctl.doPush   = candidate && !stackFull;
    ctl.setOvf   = candidate && stackFull;
    ctl.doWrite  = swWrEn && !ctl.doPop;
    ctl.doShadow = stateStrobe;
  end

  assign acceptValid = ctl.doPush;

  a_r8_atomic_holds_off: assert property (@(posedge clk) disable iff (!rstN)
    atomicActive |-> !acceptValid);
  a_r7_no_accept_on_return: assert property (@(posedge clk) disable iff (!rstN)
    retPulse |-> !acceptValid);
  a_r10_strobe_only: assert property (@(posedge clk) disable iff (!rstN)
    !stateStrobe |-> !acceptValid);
  a_r6_single_stack_op: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.doPush, ctl.doPop}));
  a_r3_level_zero_never: assert property (@(posedge clk) disable iff (!rstN)
    acceptValid |-> (winPrio != '0));
endmodule

// File: rtl/irq_accept_dp.sv
`timescale 1ns/1ps
module irq_accept_dp
  import irq_accept_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LVL_W  = 4,
  parameter int EN_BIT = 11,
  parameter int DEPTH  = 8,
  localparam int LVL_LSB = WORD_W - LVL_W,
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [WORD_W-1:0] wrData,
  input  logic [LVL_W-1:0]  winPrio,
  output logic [WORD_W-1:0] statusWord,
  output logic              lagEnable,
  output logic [LVL_W-1:0]  lagLevel,
  output logic [WORD_W-1:0] savedWord,
  output logic              stackFull,
  output logic              stackEmpty,
  output logic              overflow
);
  logic [WORD_W-1:0] lagWord;
  logic [WORD_W-1:0] stackMem [DEPTH];
  logic [CNT_W-1:0]  depthCnt;
  logic [WORD_W-1:0] mergedWord;
  logic [WORD_W-1:0] enteredWord;
  logic [WORD_W-1:0] topWord;
  logic [PTR_W-1:0]  pushIdx;
  logic [PTR_W-1:0]  topIdx;

  assign mergedWord  = ctl.doWrite ? wrData : statusWord;
  assign enteredWord = {winPrio, mergedWord[LVL_LSB-1:0]};
  assign pushIdx     = PTR_W'(depthCnt);
  assign topIdx      = PTR_W'(depthCnt - 1'b1);
  assign topWord     = stackMem[topIdx];
  assign stackFull   = (depthCnt == CNT_W'(DEPTH));
  assign stackEmpty  = (depthCnt == '0);
  assign savedWord   = mergedWord;
  assign lagEnable   = lagWord[EN_BIT];
  assign lagLevel    = lagWord[WORD_W-1:LVL_LSB];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusWord <= '0;
      lagWord    <= '0;
      depthCnt   <= '0;
      overflow   <= 1'b0;
    end else begin
      if (ctl.doPop) begin
        statusWord <= topWord;
        lagWord    <= topWord;
        depthCnt   <= depthCnt - 1'b1;
      end else if (ctl.doPush) begin
        statusWord <= enteredWord;
        lagWord    <= enteredWord;
        depthCnt   <= depthCnt + 1'b1;
      end else begin
        if (ctl.doWrite)  statusWord <= wrData;
        if (ctl.doShadow) lagWord    <= statusWord;
      end
      if (ctl.setOvf) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.doPush) stackMem[pushIdx] <= mergedWord;
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    depthCnt <= CNT_W'(DEPTH));
  a_r9_sticky_flag: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
  a_r6_level_replaced: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doPush |=> statusWord[WORD_W-1:LVL_LSB] == $past(winPrio));
  a_r7_restore_exact: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doPop |=> statusWord == $past(topWord));
  a_r4_lag_follows: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.doShadow && !ctl.doPush && !ctl.doPop) |=> lagWord == $past(statusWord));
endmodule

// File: rtl/irq_accept_unit.sv
`timescale 1ns/1ps
module irq_accept_unit
  import irq_accept_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int LVL_W   = 4,
  parameter int WORD_W  = 16,
  parameter int EN_BIT  = 11,
  parameter int DEPTH   = 8,
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     stateStrobe,
  input  logic                     swWrEn,
  input  logic [WORD_W-1:0]        swWrData,
  input  logic [NUM_REQ-1:0]       reqValid,
  input  logic [NUM_REQ*LVL_W-1:0] reqPrio,
  input  logic                     atomicActive,
  input  logic                     retPulse,
  output logic                     acceptValid,
  output logic [IDX_W-1:0]         acceptIdx,
  output logic [LVL_W-1:0]         acceptPrio,
  output logic [WORD_W-1:0]        savedWord,
  output logic [WORD_W-1:0]        statusWord,
  output logic                     stackOverflow
);
  dpCtrl_t          ctl;
  logic             lagEnable;
  logic [LVL_W-1:0] lagLevel;
  logic             stackFull;
  logic             stackEmpty;

  irq_accept_ctrl #(.NUM_REQ(NUM_REQ), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .stateStrobe(stateStrobe),
    .atomicActive(atomicActive), .retPulse(retPulse), .swWrEn(swWrEn),
    .reqValid(reqValid), .reqPrio(reqPrio), .lagEnable(lagEnable),
    .lagLevel(lagLevel), .stackFull(stackFull), .stackEmpty(stackEmpty),
    .ctl(ctl), .winIdx(acceptIdx), .winPrio(acceptPrio),
    .acceptValid(acceptValid)
  );

  irq_accept_dp #(.WORD_W(WORD_W), .LVL_W(LVL_W), .EN_BIT(EN_BIT),
                  .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(swWrData),
    .winPrio(acceptPrio), .statusWord(statusWord), .lagEnable(lagEnable),
    .lagLevel(lagLevel), .savedWord(savedWord), .stackFull(stackFull),
    .stackEmpty(stackEmpty), .overflow(stackOverflow)
  );
endmodule

// File: tb/irq_accept_unit_tb.sv
`timescale 1ns/1ps
module irq_accept_unit_tb;
  localparam int NR = 4;
  localparam logic [15:0] EN = 16'h0800;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, stateStrobe, swWrEn, atomicActive, retPulse;
  logic [15:0] swWrData;
  logic [NR-1:0]   reqValid;
  logic [NR*4-1:0] reqPrio;
  logic        acceptValid, stackOverflow;
  logic [1:0]  acceptIdx;
  logic [3:0]  acceptPrio;
  logic [15:0] savedWord, statusWord;

  int nVec = 0, nBad = 0;
  bit done = 1'b0;

  irq_accept_unit u_dut (
    .clk(clk), .rstN(rstN), .stateStrobe(stateStrobe), .swWrEn(swWrEn),
    .swWrData(swWrData), .reqValid(reqValid), .reqPrio(reqPrio),
    .atomicActive(atomicActive), .retPulse(retPulse),
    .acceptValid(acceptValid), .acceptIdx(acceptIdx), .acceptPrio(acceptPrio),
    .savedWord(savedWord), .statusWord(statusWord),
    .stackOverflow(stackOverflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  function automatic logic [15:0] lvlWord(input int l, input bit en);
    return 16'((l << 12) | (en ? 32'h0800 : 32'h0));
  endfunction

  task automatic oneReq(input int i, input int p);
    reqValid = '0;
    reqPrio  = '0;
    reqValid[i] = 1'b1;
    reqPrio[i*4 +: 4] = 4'(p);
  endtask

  task automatic noReq();
    reqValid = '0;
    reqPrio  = '0;
  endtask

  // write, then one more strobe so the lagged copy holds the new word
  task automatic setWord(input logic [15:0] w);
    swWrEn = 1'b1; swWrData = w; cyc();
    swWrEn = 1'b0; cyc();
  endtask

  task automatic doRet();
    retPulse = 1'b1; cyc(); retPulse = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    rstN = 1'b0; stateStrobe = 1'b1; swWrEn = 1'b0; swWrData = '0;
    atomicActive = 1'b0; retPulse = 1'b0; noReq();
    repeat (3) cyc();
    rstN = 1'b1;
    oneReq(0, 5); #1;
    chk("R1 status", 32'(statusWord), 32'h0);
    chk("R1 overflow", 32'(stackOverflow), 0);
    chk("R1 no accept", 32'(acceptValid), 0);
    noReq(); cyc();

    // R2: write visible after the edge
    swWrEn = 1'b1; swWrData = lvlWord(3, 1); cyc();
    chk("R2 write visible", 32'(statusWord), 32'(lvlWord(3, 1)));
    swWrEn = 1'b0; cyc();

    // R3 sweep: every level against every priority, enabled and disabled
    for (int en = 0; en < 2; en++) begin
      for (int l = 0; l < 16; l++) begin
        setWord(lvlWord(l, en[0]));
        for (int p = 0; p < 16; p++) begin
          oneReq(0, p); #1;
          chk($sformatf("R3 accept L%0d P%0d E%0d", l, p, en), 32'(acceptValid),
              32'((en == 1) && (p > l)));
          if (acceptValid) chk("R6 saved", 32'(savedWord), 32'(lvlWord(l, en[0])));
          cyc();
          noReq();
          if ((en == 1) && (p > l)) begin
            chk("R6 level raised", 32'(statusWord), 32'(lvlWord(p, 1)));
            doRet();
            chk("R7 restored", 32'(statusWord), 32'(lvlWord(l, 1)));
          end
        end
      end
    end

    // R5 sweep: pseudo-random multi-request arbitration at level 0
    setWord(EN);
    seed = 32'h1234_5678;
    for (int t = 0; t < 300; t++) begin
      int best, bidx;
      seed = seed * 32'd1664525 + 32'd1013904223;
      reqValid = seed[3:0];
      reqPrio  = seed[27:12];
      best = 0; bidx = 0;
      for (int i = 0; i < NR; i++)
        if (reqValid[i] && (int'(reqPrio[i*4 +: 4]) > best)) begin
          best = int'(reqPrio[i*4 +: 4]); bidx = i;
        end
      #1;
      chk("R5 accept", 32'(acceptValid), 32'(best > 0));
      if (best > 0) begin
        chk("R5 index", 32'(acceptIdx), 32'(bidx));
        chk("R5 prio", 32'(acceptPrio), 32'(best));
      end
      cyc(); noReq();
      if (best > 0) doRet();
    end

    // R4/R6/R7: write of level 15 while a level-2 request arrives
    setWord(EN);
    swWrEn = 1'b1; swWrData = 16'hF800; oneReq(0, 2); #1;
    chk("R4 gap accept", 32'(acceptValid), 1);
    chk("R6 saved new word", 32'(savedWord), 32'hF800);
    cyc(); swWrEn = 1'b0;
    chk("R6 level 2", 32'(statusWord), 32'h2800);
    oneReq(1, 3); #1;
    chk("R6 higher nests", 32'(acceptValid), 1);
    chk("R5 nest index", 32'(acceptIdx), 1);
    cyc();
    chk("R6 level 3", 32'(statusWord), 32'h3800);
    #1 chk("R3 equal level refused", 32'(acceptValid), 0);
    noReq();
    doRet(); chk("R7 pop 1", 32'(statusWord), 32'h2800);
    doRet(); chk("R7 pop to 15", 32'(statusWord), 32'hF800);
    oneReq(2, 14); #1;
    chk("R7 level 15 masks", 32'(acceptValid), 0);
    noReq(); cyc();

    // R4: clearing enable still lets the next state accept
    setWord(EN);
    swWrEn = 1'b1; swWrData = 16'h0000; cyc();
    swWrEn = 1'b0; oneReq(0, 5); #1;
    chk("R4 in-flight accept", 32'(acceptValid), 1);
    cyc(); noReq();
    doRet(); chk("R7 restore cleared", 32'(statusWord), 32'h0);
    oneReq(0, 5); #1;
    chk("R3 disabled", 32'(acceptValid), 0);
    noReq(); cyc();

    // R4/R10: lag does not move without strobes
    setWord(EN);
    stateStrobe = 1'b0; swWrEn = 1'b1; swWrData = 16'h0000; cyc();
    swWrEn = 1'b0; oneReq(0, 9); #1;
    chk("R10 no strobe", 32'(acceptValid), 0);
    cyc(); cyc();
    stateStrobe = 1'b1; #1;
    chk("R4 lag held", 32'(acceptValid), 1);
    cyc(); noReq();
    doRet(); chk("R7 restore", 32'(statusWord), 32'h0);

    // R8 atomic
    setWord(EN);
    atomicActive = 1'b1; oneReq(3, 9); #1;
    chk("R8 atomic blocks", 32'(acceptValid), 0);
    cyc();
    chk("R8 status kept", 32'(statusWord), 32'(EN));
    atomicActive = 1'b0; #1;
    chk("R8 after release", 32'(acceptValid), 1);
    cyc();
    // R7: return cycle refuses a request
    oneReq(0, 12); retPulse = 1'b1; #1;
    chk("R7 no accept on return", 32'(acceptValid), 0);
    cyc(); retPulse = 1'b0; noReq();
    chk("R7 restore after atomic", 32'(statusWord), 32'(EN));
    doRet();
    chk("R7 empty return", 32'(statusWord), 32'(EN));

    // R9 overflow
    for (int k = 1; k <= 8; k++) begin
      oneReq(0, k); #1;
      chk("R9 fill", 32'(acceptValid), 1);
      cyc();
    end
    oneReq(0, 9); #1;
    chk("R9 refused", 32'(acceptValid), 0);
    cyc(); noReq();
    chk("R9 flag", 32'(stackOverflow), 1);
    chk("R9 status kept", 32'(statusWord), 32'(lvlWord(8, 1)));
    for (int k = 8; k >= 1; k--) begin
      doRet();
      chk("R9 unwind", 32'(statusWord), 32'(lvlWord(k - 1, 1)));
    end
    chk("R9 sticky", 32'(stackOverflow), 1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule